// File: doc/BRIEF.md
# Readout Monitoring Counter Bank

This block gathers running statistics for a readout path built from two streams and presents them as 32-bit words on a small read port. For each of the two streams it takes one representative FIFO fill level, since every FIFO in a stream shares the same occupancy. It keeps a high-water mark for that level and reports the mark together with the current level in one word. It also follows the busy flag of each stream, counting both how many times busy goes active and how many clock ticks busy stays active.

It counts the ECR and L1A strobes, runs a tick counter, and counts output words on the 64-bit output stream that repeat the word sent before them. The counters fall into four groups, and each group has its own clear pulse. Every counter saturates at all-ones. A bus slave reads the block by placing an address and taking the data one clock later.

Top module: `rdmon_bank`

## Requirements
- R1: After the synchronous reset, every readable register reads as zero.
- R2: `rd_data` shows, one clock after it, the register chosen by `rd_addr`: 0 and 1 occupancy of stream 0 and stream 1, 2 and 3 busy-edge count of stream 0 and 1, 4 and 5 busy-duration count of stream 0 and 1, 6 ECR count, 7 L1A count, 8 tick count, 9 repeated-word count. Addresses 10 to 15 read as zero.
- R3: The occupancy word holds the high-water mark in bits 31:16 and, in bits 15:0, the fill level sampled on the previous clock. Unused upper bits of a narrower field read as zero.
- R4: The high-water mark takes the live fill level whenever that level is above the stored mark. When a clear and a larger level arrive in the same clock, the clear wins and the mark becomes zero.
- R5: Each busy-edge count goes up by one on every clock where the stream's busy flag is high and was low on the clock before. A long busy period counts once.
- R6: Each busy-duration count goes up by one on every clock where the stream's busy flag is high.
- R7: The tick count goes up by one on every clock.
- R8: `clr_busy` zeroes both high-water marks, both busy-edge counts, both busy-duration counts and the tick count on the next clock. It has no effect on the ECR, L1A or repeated-word counts.
- R9: The ECR count goes up by one for each clock with `ecr_pulse` high, and only `clr_ecr` (or reset) zeroes it.
- R10: The L1A count goes up by one for each clock with `l1a_pulse` high, and only `clr_l1a` (or reset) zeroes it.
- R11: The repeated-word count goes up by one for each clock where `word_valid` is high and `word_data` equals the last valid word seen since reset. Only `clr_dw` (or reset) zeroes it. Clearing the count does not forget the last word.
- R12: All counts hold at all-ones rather than wrapping. When a clear and an increment arrive in the same clock, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_lvl | input | 2*FILL_W | Fill level of each stream, stream 0 in the low field |
| busy | input | 2 | Busy flag of each stream |
| ecr_pulse | input | 1 | ECR strobe |
| l1a_pulse | input | 1 | L1A strobe |
| word_data | input | DATA_W | Output word stream |
| word_valid | input | 1 | Output word valid |
| clr_busy | input | 1 | Clears high-water marks, busy counts, durations and the tick count |
| clr_ecr | input | 1 | Clears the ECR count |
| clr_l1a | input | 1 | Clears the L1A count |
| clr_dw | input | 1 | Clears the repeated-word count |
| rd_addr | input | 4 | Register select |
| rd_data | output | 32 | Registered read data |

## Verification
The assertions assume that reset is held from time zero until the first clocks have passed. They also assume the clear pulses are single-clock strobes, and that a clear may share a clock with any increment. No property is written about the level of the inputs, so the bench drives every input freely from a pseudo-random source. Clears and strobes are made to collide on purpose, and a phase with no clears runs long enough to push the 8-bit counts of the small configuration into saturation.

// File: rtl/rdmon_pkg.sv
package rdmon_pkg;
  localparam int RD_W   = 32;
  localparam int TM_LSB = 16;
  localparam int NCH    = 2;
  localparam int NREG   = 10;
  localparam int AW     = 4;

  localparam logic [AW-1:0] A_OCC0  = 4'd0;
  localparam logic [AW-1:0] A_OCC1  = 4'd1;
  localparam logic [AW-1:0] A_BCNT0 = 4'd2;
  localparam logic [AW-1:0] A_BCNT1 = 4'd3;
  localparam logic [AW-1:0] A_BDUR0 = 4'd4;
  localparam logic [AW-1:0] A_BDUR1 = 4'd5;
  localparam logic [AW-1:0] A_ECR   = 4'd6;
  localparam logic [AW-1:0] A_L1A   = 4'd7;
  localparam logic [AW-1:0] A_TICK  = 4'd8;
  localparam logic [AW-1:0] A_DW    = 4'd9;
endpackage

// File: rtl/rdmon_satcnt.sv
module rdmon_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && (cnt != {W{1'b1}}))
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rdmon_tidemark.sv
module rdmon_tidemark #(
  parameter int FILL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [FILL_W-1:0] fill,
  output logic [FILL_W-1:0] fill_q,
  output logic [FILL_W-1:0] tide
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      tide   <= '0;
    end else begin
      fill_q <= fill;
      if (clr)
        tide <= '0;
      else if (fill > tide)
        tide <= fill;
    end
  end
endmodule

// File: rtl/rdmon_chan.sv
module rdmon_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             busy,
  output logic [CNT_W-1:0] edge_cnt,
  output logic [CNT_W-1:0] dur_cnt
);
  logic busy_q;
  logic busy_rise;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy;
  end

  assign busy_rise = busy && !busy_q;

  rdmon_satcnt #(.W(CNT_W)) u_edge (
    .clk(clk), .rst(rst), .clr(clr), .inc(busy_rise), .cnt(edge_cnt)
  );

  rdmon_satcnt #(.W(CNT_W)) u_dur (
    .clk(clk), .rst(rst), .clr(clr), .inc(busy), .cnt(dur_cnt)
  );
endmodule

// File: rtl/rdmon_bank.sv
module rdmon_bank
  import rdmon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int FILL_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH*FILL_W-1:0] fill_lvl,
  input  logic [NCH-1:0]        busy,
  input  logic                  ecr_pulse,
  input  logic                  l1a_pulse,
  input  logic [DATA_W-1:0]     word_data,
  input  logic                  word_valid,
  input  logic                  clr_busy,
  input  logic                  clr_ecr,
  input  logic                  clr_l1a,
  input  logic                  clr_dw,
  input  logic [AW-1:0]         rd_addr,
  output logic [RD_W-1:0]       rd_data
);
  logic [NCH*FILL_W-1:0] fillq_all;
  logic [NCH*FILL_W-1:0] tide_all;
  logic [NCH*CNT_W-1:0]  bcnt_all;
  logic [NCH*CNT_W-1:0]  bdur_all;
  logic [CNT_W-1:0]      ecr_cnt;
  logic [CNT_W-1:0]      l1a_cnt;
  logic [CNT_W-1:0]      tick_cnt;
  logic [CNT_W-1:0]      dw_cnt;

  // per-stream occupancy and busy statistics
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    rdmon_tidemark #(.FILL_W(FILL_W)) u_tm (
      .clk(clk), .rst(rst), .clr(clr_busy),
      .fill(fill_lvl[ch*FILL_W +: FILL_W]),
      .fill_q(fillq_all[ch*FILL_W +: FILL_W]),
      .tide(tide_all[ch*FILL_W +: FILL_W])
    );
    rdmon_chan #(.CNT_W(CNT_W)) u_busy (
      .clk(clk), .rst(rst), .clr(clr_busy), .busy(busy[ch]),
      .edge_cnt(bcnt_all[ch*CNT_W +: CNT_W]),
      .dur_cnt(bdur_all[ch*CNT_W +: CNT_W])
    );
  end

  rdmon_satcnt #(.W(CNT_W)) u_ecr (
    .clk(clk), .rst(rst), .clr(clr_ecr), .inc(ecr_pulse), .cnt(ecr_cnt)
  );
  rdmon_satcnt #(.W(CNT_W)) u_l1a (
    .clk(clk), .rst(rst), .clr(clr_l1a), .inc(l1a_pulse), .cnt(l1a_cnt)
  );
  rdmon_satcnt #(.W(CNT_W)) u_tick (
    .clk(clk), .rst(rst), .clr(clr_busy), .inc(1'b1), .cnt(tick_cnt)
  );

  // repeated output word detection
  logic [DATA_W-1:0] last_word;
  logic              have_last;
  logic              word_rep;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_word <= '0;
      have_last <= 1'b0;
    end else if (word_valid) begin
      last_word <= word_data;
      have_last <= 1'b1;
    end
  end

  assign word_rep = word_valid && have_last && (word_data == last_word);

  rdmon_satcnt #(.W(CNT_W)) u_dw (
    .clk(clk), .rst(rst), .clr(clr_dw), .inc(word_rep), .cnt(dw_cnt)
  );

  // read mux, registered
  logic [RD_W-1:0] rd_sel;

  always_comb begin
    rd_sel = '0;
    case (rd_addr)
      A_OCC0: begin
        rd_sel[TM_LSB +: FILL_W] = tide_all[0 +: FILL_W];
        rd_sel[FILL_W-1:0]       = fillq_all[0 +: FILL_W];
      end
      A_OCC1: begin
        rd_sel[TM_LSB +: FILL_W] = tide_all[FILL_W +: FILL_W];
        rd_sel[FILL_W-1:0]       = fillq_all[FILL_W +: FILL_W];
      end
      A_BCNT0: rd_sel[CNT_W-1:0] = bcnt_all[0 +: CNT_W];
      A_BCNT1: rd_sel[CNT_W-1:0] = bcnt_all[CNT_W +: CNT_W];
      A_BDUR0: rd_sel[CNT_W-1:0] = bdur_all[0 +: CNT_W];
      A_BDUR1: rd_sel[CNT_W-1:0] = bdur_all[CNT_W +: CNT_W];
      A_ECR:   rd_sel[CNT_W-1:0] = ecr_cnt;
      A_L1A:   rd_sel[CNT_W-1:0] = l1a_cnt;
      A_TICK:  rd_sel[CNT_W-1:0] = tick_cnt;
      A_DW:    rd_sel[CNT_W-1:0] = dw_cnt;
      default: rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel;
  end
endmodule

// File: rtl/rdmon_chk.sv
module rdmon_chk
  import rdmon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int FILL_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  clr_busy,
  input logic                  clr_ecr,
  input logic                  clr_l1a,
  input logic                  clr_dw,
  input logic [AW-1:0]         rd_addr,
  input logic [RD_W-1:0]       rd_data,
  input logic [NCH*FILL_W-1:0] tide_all,
  input logic [NCH*CNT_W-1:0]  bcnt_all,
  input logic [NCH*CNT_W-1:0]  bdur_all,
  input logic [CNT_W-1:0]      ecr_cnt,
  input logic [CNT_W-1:0]      l1a_cnt,
  input logic [CNT_W-1:0]      tick_cnt,
  input logic [CNT_W-1:0]      dw_cnt
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr >= AW'(NREG)) |=> (rd_data == '0));

  // R4
  tide_mono0_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_busy |=> (tide_all[0 +: FILL_W] >= $past(tide_all[0 +: FILL_W])));

  // R4
  tide_mono1_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_busy |=> (tide_all[FILL_W +: FILL_W] >= $past(tide_all[FILL_W +: FILL_W])));

  // R5
  edge_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_busy |=> (bcnt_all[0 +: CNT_W] >= $past(bcnt_all[0 +: CNT_W])));

  // R6
  dur_le_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (bdur_all[0 +: CNT_W] <= tick_cnt) && (bdur_all[CNT_W +: CNT_W] <= tick_cnt));

  // R7
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_busy && tick_cnt != CMAX) |=> (tick_cnt == $past(tick_cnt) + 1'b1));

  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_busy |=> (tick_cnt == '0 && bcnt_all == '0 && bdur_all == '0 && tide_all == '0));

  // R9
  ecr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_ecr |=> (ecr_cnt == '0));

  // R10
  l1a_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_l1a |=> (l1a_cnt == '0));

  // R11
  dw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_dw |=> (dw_cnt == '0));

  // R12
  tick_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_cnt == CMAX && !clr_busy) |=> (tick_cnt == CMAX));
endmodule

bind rdmon_bank rdmon_chk #(.CNT_W(CNT_W), .FILL_W(FILL_W)) u_chk (
  .clk(clk), .rst(rst), .clr_busy(clr_busy), .clr_ecr(clr_ecr),
  .clr_l1a(clr_l1a), .clr_dw(clr_dw), .rd_addr(rd_addr), .rd_data(rd_data),
  .tide_all(tide_all), .bcnt_all(bcnt_all), .bdur_all(bdur_all),
  .ecr_cnt(ecr_cnt), .l1a_cnt(l1a_cnt), .tick_cnt(tick_cnt), .dw_cnt(dw_cnt)
);

// File: tb/tb_rdmon_bank.sv
module tb_rdmon_bank;
  localparam int CNT_W  = 8;
  localparam int FILL_W = 16;
  localparam int DATA_W = 64;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [2*FILL_W-1:0]   fill_lvl = '0;
  logic [1:0]            busy = '0;
  logic                  ecr_pulse = 1'b0, l1a_pulse = 1'b0;
  logic [DATA_W-1:0]     word_data = '0;
  logic                  word_valid = 1'b0;
  logic                  clr_busy = 1'b0, clr_ecr = 1'b0, clr_l1a = 1'b0, clr_dw = 1'b0;
  logic [3:0]            rd_addr = '0;
  logic [31:0]           rd_data;

  always #2 clk = ~clk;

  rdmon_bank #(.CNT_W(CNT_W), .FILL_W(FILL_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .fill_lvl(fill_lvl), .busy(busy),
    .ecr_pulse(ecr_pulse), .l1a_pulse(l1a_pulse),
    .word_data(word_data), .word_valid(word_valid),
    .clr_busy(clr_busy), .clr_ecr(clr_ecr), .clr_l1a(clr_l1a), .clr_dw(clr_dw),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_vec = 0, n_bad = 0;
  string phase = "R8";
  logic [31:0] seed = 32'h1234_5678;

  // reference model state
  int m_tide[2], m_fq[2], m_bq[2], m_bc[2], m_bd[2];
  int m_ecr, m_l1a, m_tick, m_dw;
  logic [DATA_W-1:0] m_last;
  bit m_have;

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic int sat(int v, bit clr, bit inc);
    if (clr) return 0;
    if (inc && v < CMAX) return v + 1;
    return v;
  endfunction

  function automatic logic [31:0] model_rd(logic [3:0] a);
    case (a)
      4'd0: return (32'(m_tide[0]) << 16) | 32'(m_fq[0]);
      4'd1: return (32'(m_tide[1]) << 16) | 32'(m_fq[1]);
      4'd2: return 32'(m_bc[0]);
      4'd3: return 32'(m_bc[1]);
      4'd4: return 32'(m_bd[0]);
      4'd5: return 32'(m_bd[1]);
      4'd6: return 32'(m_ecr);
      4'd7: return 32'(m_l1a);
      4'd8: return 32'(m_tick);
      4'd9: return 32'(m_dw);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] a);
    case (a)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R5";
      4'd4, 4'd5: return "R6";
      4'd6: return "R9";
      4'd7: return "R10";
      4'd8: return "R7";
      4'd9: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_tide[c] = 0; m_fq[c] = 0; m_bq[c] = 0; m_bc[c] = 0; m_bd[c] = 0;
    end
    m_ecr = 0; m_l1a = 0; m_tick = 0; m_dw = 0; m_last = '0; m_have = 0;
  endtask

  // one clock: inputs already driven; checks the read issued on this clock
  task automatic tick();
    logic [31:0] exp;
    logic [3:0]  a;
    a   = rd_addr;
    exp = model_rd(a);
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      int f;
      f = int'(fill_lvl[c*FILL_W +: FILL_W]);
      m_fq[c] = f;
      if (clr_busy) m_tide[c] = 0;
      else if (f > m_tide[c]) m_tide[c] = f;
      m_bc[c] = sat(m_bc[c], clr_busy, busy[c] && !m_bq[c][0]);
      m_bd[c] = sat(m_bd[c], clr_busy, busy[c]);
      m_bq[c] = int'(busy[c]);
    end
    m_ecr  = sat(m_ecr,  clr_ecr,  ecr_pulse);
    m_l1a  = sat(m_l1a,  clr_l1a,  l1a_pulse);
    m_tick = sat(m_tick, clr_busy, 1'b1);
    m_dw   = sat(m_dw,   clr_dw,   word_valid && m_have && word_data == m_last);
    if (word_valid) begin m_last = word_data; m_have = 1; end
    @(negedge clk);
    n_vec++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s/%s addr %0d: got %h expected %h", req_of(a), phase, a, rd_data, exp);
    end
    rd_addr = rd_addr + 4'd1;
  endtask

  task automatic drive_random(int clr_mask);
    logic [31:0] r;
    r = rnd();
    fill_lvl   = {4'd0, 12'(rnd()), 4'd0, 12'(rnd())};
    if (r[2:0] == 3'd0) busy[0] = ~busy[0];
    if (r[5:3] == 3'd0) busy[1] = ~busy[1];
    ecr_pulse  = r[6] & r[7];
    l1a_pulse  = r[8];
    word_valid = r[9] | r[10];
    word_data  = {62'd0, r[12:11]} * 64'h0123_4567_89ab_cdef;
    clr_busy   = clr_mask[0] && (r[18:13] == 6'd0);
    clr_ecr    = clr_mask[1] && (r[24:19] == 6'd0);
    clr_l1a    = clr_mask[2] && (r[30:25] == 6'd0);
    clr_dw     = clr_mask[3] && (r[31] & r[0] & r[1] & r[13]);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, one read per address with idle inputs
    for (int i = 0; i < 16; i++) begin
      phase = "R1";
      tick();
    end
    // R8: free random traffic with all clear pulses active at random
    phase = "R8";
    for (int i = 0; i < 3000; i++) begin
      drive_random(15);
      tick();
    end
    // R12: no clears, counters driven into saturation
    phase = "R12";
    for (int i = 0; i < 700; i++) begin
      drive_random(0);
      busy      = {busy[0], ~busy[0]};
      ecr_pulse = 1'b1;
      word_valid = 1'b1;
      word_data  = 64'hdead_beef_0000_0001;
      tick();
    end
    // R4: clears colliding with increments and larger fill levels
    phase = "R4";
    for (int i = 0; i < 320; i++) begin
      drive_random(0);
      fill_lvl  = {16'hffff - 16'(i), 16'hff00 + 16'(i)};
      clr_busy  = (i % 5) == 0;
      clr_ecr   = (i % 7) == 0;
      clr_l1a   = (i % 3) == 0;
      clr_dw    = (i % 11) == 0;
      ecr_pulse = 1'b1;
      l1a_pulse = 1'b1;
      tick();
    end
    drive_random(0);
    clr_busy = 1'b0; clr_ecr = 1'b0; clr_l1a = 1'b0; clr_dw = 1'b0;
    for (int i = 0; i < 32; i++) tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule